// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This combinational unit inspects a 32-bit single-precision word and reports its operand class: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. One mode input chooses how the top fraction bit is read. In the newer encoding a set top fraction bit marks a quiet NaN. In the legacy encoding a set top fraction bit marks a signaling NaN.

When a quiet request arrives with a signaling NaN, the unit rewrites the word into a quiet NaN under the active encoding and raises an invalid-operation flag. In every other case the word passes through unchanged. In legacy mode, clearing the top fraction bit could leave a zero fraction, and the word would then read as infinity. The unit prevents this by setting the next fraction bit down. An execution pipeline uses the unit on operands before arithmetic and on NaN results before they are written back.

Top module: `fp_nan_unit`

## Requirements
- R1: A word is a NaN when its exponent (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. An all-ones exponent with a zero fraction is infinity, and `is_nan_o` stays low for it.
- R2: With `legacy_mode_i`=0, a NaN is signaling when fraction bit 22 is 0, and quiet when bit 22 is 1.
- R3: With `legacy_mode_i`=1, a NaN is signaling when fraction bit 22 is 1, and quiet when bit 22 is 0.
- R4: Quieting a signaling NaN with `legacy_mode_i`=0 sets bit 22. All other bits of the word, including sign and exponent, are unchanged.
- R5: Quieting a signaling NaN with `legacy_mode_i`=1 clears bit 22. Sign, exponent and the other fraction bits are unchanged, as long as the remaining fraction is nonzero.
- R6: In legacy quieting, if clearing bit 22 leaves an all-zero fraction, bit 21 is set so that the result stays a NaN.
- R7: `invalid_o` is 1 exactly when `quiet_req_i` is 1 and the input is a signaling NaN under the active mode.
- R8: When `quiet_req_i` is 0, or the input is not a signaling NaN, `word_o` equals `word_i`.
- R9: `class_o` encodes the class as follows: 0 zero, 1 subnormal (exponent 0, fraction nonzero), 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN. The sign does not affect the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 32 | Operand word |
| legacy_mode_i | input | 1 | 1 selects legacy NaN encoding |
| quiet_req_i | input | 1 | Request to quiet a signaling NaN |
| word_o | output | 32 | Quieted or passed-through word |
| is_nan_o | output | 1 | Input is a NaN |
| is_snan_o | output | 1 | Input is a signaling NaN |
| invalid_o | output | 1 | Invalid-operation flag |
| class_o | output | 3 | Operand class code |

## Verification
Immediate assertions are evaluated on every input change. They check the following:
- a quieted result is still a NaN and is quiet under the active mode;
- sign and exponent survive quieting;
- the word passes through whenever no invalid flag is raised;
- the flag appears only for a signaling input;
- the NaN flags agree with the class code.

Only the bench scenarios can show the exact bit patterns. These are the specific bit set or cleared in each mode, the bit-21 guard on a legacy payload that would otherwise become zero, and the class codes for zero, subnormal, normal and infinity inputs.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;
endpackage

// File: rtl/fp_field_split.sv
module fp_field_split #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W-1:0]     frac_o,
  output logic                  exp_ones_o,
  output logic                  exp_zero_o,
  output logic                  frac_zero_o
);
  assign sign_o      = word_i[EXP_W+FRAC_W];
  assign exp_o       = word_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_o      = word_i[FRAC_W-1:0];
  assign exp_ones_o  = &exp_o;
  assign exp_zero_o  = ~|exp_o;
  assign frac_zero_o = ~|frac_o;
endmodule

// File: rtl/fp_nan_detect.sv
module fp_nan_detect
  import fp_nan_pkg::*;
(
  input  logic      exp_ones_i,
  input  logic      exp_zero_i,
  input  logic      frac_zero_i,
  input  logic      qbit_i,
  input  logic      legacy_i,
  output logic      is_nan_o,
  output logic      is_snan_o,
  output fp_class_e class_o
);
  assign is_nan_o  = exp_ones_i & ~frac_zero_i;
  // signaling when quiet-indicator bit equals the legacy flag
  assign is_snan_o = is_nan_o & (qbit_i == legacy_i);

  always_comb begin
    if (exp_ones_i)
      class_o = frac_zero_i ? CLS_INF : (is_snan_o ? CLS_SNAN : CLS_QNAN);
    else if (exp_zero_i)
      class_o = frac_zero_i ? CLS_ZERO : CLS_SUB;
    else
      class_o = CLS_NORM;
  end

  always_comb begin
    AST_SNAN_IS_NAN: assert (!is_snan_o || is_nan_o); // R2
    AST_INF_NOT_NAN: assert (!(exp_ones_i && frac_zero_i) || !is_nan_o); // R1
  end
endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  sign_i,
  input  logic [EXP_W-1:0]      exp_i,
  input  logic [FRAC_W-1:0]     frac_i,
  input  logic                  is_snan_i,
  input  logic                  legacy_i,
  input  logic                  req_i,
  output logic [EXP_W+FRAC_W:0] word_o,
  output logic                  invalid_o
);
  localparam int QB = FRAC_W - 1;
  localparam int GB = FRAC_W - 2;

  logic              fire;
  logic [FRAC_W-1:0] frac_q;

  assign fire = req_i & is_snan_i;

  always_comb begin
    frac_q = frac_i;
    if (fire) begin
      if (!legacy_i) begin
        frac_q[QB] = 1'b1;
      end else begin
        frac_q[QB] = 1'b0;
        if (frac_q == '0) frac_q[GB] = 1'b1; // keep result a NaN
      end
    end
  end

  assign word_o    = {sign_i, exp_i, frac_q};
  assign invalid_o = fire;

  always_comb begin
    AST_QUIET_STAYS_NAN: assert (!invalid_o || ((&word_o[EXP_W+FRAC_W-1:FRAC_W]) && (|word_o[FRAC_W-1:0]))); // R6
    AST_OUT_IS_QUIET: assert (!invalid_o || (word_o[QB] != legacy_i)); // R5
    AST_HEAD_KEPT: assert (word_o[EXP_W+FRAC_W:FRAC_W] == {sign_i, exp_i}); // R4
    AST_PASS_THRU: assert (invalid_o || (word_o[FRAC_W-1:0] == frac_i)); // R8
    AST_FLAG_NEEDS_SNAN: assert (!invalid_o || (is_snan_i && req_i)); // R7
  end
endmodule

// File: rtl/fp_nan_unit.sv
module fp_nan_unit
  import fp_nan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  input  logic                  legacy_mode_i,
  input  logic                  quiet_req_i,
  output logic [EXP_W+FRAC_W:0] word_o,
  output logic                  is_nan_o,
  output logic                  is_snan_o,
  output logic                  invalid_o,
  output logic [2:0]            class_o
);
  logic              sign;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones, exp_zero, frac_zero;
  fp_class_e         cls;

  fp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
    .word_i      (word_i),
    .sign_o      (sign),
    .exp_o       (exp_f),
    .frac_o      (frac_f),
    .exp_ones_o  (exp_ones),
    .exp_zero_o  (exp_zero),
    .frac_zero_o (frac_zero)
  );

  fp_nan_detect u_detect (
    .exp_ones_i  (exp_ones),
    .exp_zero_i  (exp_zero),
    .frac_zero_i (frac_zero),
    .qbit_i      (frac_f[FRAC_W-1]),
    .legacy_i    (legacy_mode_i),
    .is_nan_o    (is_nan_o),
    .is_snan_o   (is_snan_o),
    .class_o     (cls)
  );

  fp_nan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .sign_i    (sign),
    .exp_i     (exp_f),
    .frac_i    (frac_f),
    .is_snan_i (is_snan_o),
    .legacy_i  (legacy_mode_i),
    .req_i     (quiet_req_i),
    .word_o    (word_o),
    .invalid_o (invalid_o)
  );

  assign class_o = cls;

  always_comb begin
    AST_NAN_MATCH_CLASS: assert (is_nan_o == (class_o == CLS_QNAN || class_o == CLS_SNAN)); // R9
    AST_SNAN_MATCH_CLASS: assert (is_snan_o == (class_o == CLS_SNAN)); // R9
    AST_NO_REQ_PASS: assert (quiet_req_i || (word_o == word_i && !invalid_o)); // R8
  end
endmodule

// File: tb/fp_nan_unit_test.sv
module fp_nan_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word_i = '0;
  logic        legacy_mode_i = 1'b0;
  logic        quiet_req_i = 1'b0;
  logic [31:0] word_o;
  logic        is_nan_o, is_snan_o, invalid_o;
  logic [2:0]  class_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_nan_unit uut (
    .word_i        (word_i),
    .legacy_mode_i (legacy_mode_i),
    .quiet_req_i   (quiet_req_i),
    .word_o        (word_o),
    .is_nan_o      (is_nan_o),
    .is_snan_o     (is_snan_o),
    .invalid_o     (invalid_o),
    .class_o       (class_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] w, logic leg, logic req);
    @(posedge clk);
    word_i = w; legacy_mode_i = leg; quiet_req_i = req;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R9", "reset class", {29'd0, class_o}, 32'd0);
    check("R8", "reset word", word_o, 32'h0);
    check("R7", "reset invalid", {31'd0, invalid_o}, 32'd0);
  endtask

  task automatic t_new_snan();
    drive(32'h7F80_0001, 1'b0, 1'b1);
    check("R4", "new quiet word", word_o, 32'h7FC0_0001);
    check("R7", "new invalid", {31'd0, invalid_o}, 32'd1);
    check("R2", "new snan flag", {31'd0, is_snan_o}, 32'd1);
    check("R9", "snan class", {29'd0, class_o}, 32'd5);
    drive(32'hFFA0_0000, 1'b0, 1'b1);
    check("R4", "new quiet neg word", word_o, 32'hFFE0_0000);
  endtask

  task automatic t_new_qnan();
    drive(32'h7FC0_0000, 1'b0, 1'b1);
    check("R8", "new qnan pass", word_o, 32'h7FC0_0000);
    check("R7", "new qnan no invalid", {31'd0, invalid_o}, 32'd0);
    check("R2", "new qnan not snan", {31'd0, is_snan_o}, 32'd0);
    check("R9", "qnan class", {29'd0, class_o}, 32'd4);
  endtask

  task automatic t_infinity();
    drive(32'hFF80_0000, 1'b0, 1'b1);
    check("R1", "inf not nan", {31'd0, is_nan_o}, 32'd0);
    check("R9", "inf class", {29'd0, class_o}, 32'd3);
    check("R8", "inf pass", word_o, 32'hFF80_0000);
  endtask

  task automatic t_legacy_snan();
    drive(32'hFFC0_1234, 1'b1, 1'b1);
    check("R3", "leg snan flag", {31'd0, is_snan_o}, 32'd1);
    check("R5", "leg quiet word", word_o, 32'hFF80_1234);
    check("R7", "leg invalid", {31'd0, invalid_o}, 32'd1);
  endtask

  task automatic t_legacy_guard();
    drive(32'h7FC0_0000, 1'b1, 1'b1);
    check("R6", "leg guard word", word_o, 32'h7FA0_0000);
    check("R1", "leg guard nan in", {31'd0, is_nan_o}, 32'd1);
  endtask

  task automatic t_legacy_qnan();
    drive(32'h7F80_0001, 1'b1, 1'b1);
    check("R3", "leg qnan not snan", {31'd0, is_snan_o}, 32'd0);
    check("R8", "leg qnan pass", word_o, 32'h7F80_0001);
    check("R7", "leg qnan no invalid", {31'd0, invalid_o}, 32'd0);
  endtask

  task automatic t_no_request();
    drive(32'h7F80_0001, 1'b0, 1'b0);
    check("R8", "no req pass", word_o, 32'h7F80_0001);
    check("R7", "no req no invalid", {31'd0, invalid_o}, 32'd0);
    check("R2", "no req snan flag", {31'd0, is_snan_o}, 32'd1);
  endtask

  task automatic t_classes();
    drive(32'h8000_0000, 1'b0, 1'b1);
    check("R9", "neg zero class", {29'd0, class_o}, 32'd0);
    drive(32'h0000_0001, 1'b0, 1'b1);
    check("R9", "subnormal class", {29'd0, class_o}, 32'd1);
    check("R1", "subnormal not nan", {31'd0, is_nan_o}, 32'd0);
    drive(32'h3F80_0000, 1'b1, 1'b1);
    check("R9", "normal class", {29'd0, class_o}, 32'd2);
    check("R8", "normal pass", word_o, 32'h3F80_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_new_snan();
    t_new_qnan();
    t_infinity();
    t_legacy_snan();
    t_legacy_guard();
    t_legacy_qnan();
    t_no_request();
    t_classes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule